// File: doc/BRIEF.md
# Flash Command Write-Protection Filter

This block sits in the command path between a host-side requester and a serial flash controller. It inspects every flash command before the command reaches the controller. Each command carries a 3-bit opcode index and a 24-bit flash address. A programmable opcode-type table marks each opcode index as either a read type or a write type. Read-type commands are always forwarded. A write-type command is dropped in two cases: when the global write-enable bit is 0, or when its address falls inside any enabled protected window. Each window is defined by an inclusive base and limit.

Configuration is held in a small register file with a simple write-only port. Three set-only lock bits freeze the window registers, the opcode-type table and the global write-enable bit. Only reset clears a lock. A dropped command is consumed without being forwarded. It raises a one-cycle `blocked` pulse and sets a sticky error flag, which software clears by writing 1.

Control is a three-state machine. `ST_IDLE` accepts a command (`cmd_ready` high). On acceptance it moves to `ST_PASS` if the registered decision allows the command, or to `ST_BLOCK` if the command is dropped. `ST_PASS` presents the command downstream and returns to `ST_IDLE` when `fwd_ready` is high. `ST_BLOCK` lasts exactly one cycle and always returns to `ST_IDLE`.

Configuration addresses are as follows:
- 0..3: window base.
- 4..7: window limit.
- 8: window enables, bits 3:0.
- 9: opcode-type table, bits 7:0, where bit i = 1 makes index i a write type.
- 10: control. Bit 0 is write-enable, bit 1 is the write-enable lock, bit 2 is the window lock and bit 3 is the type-table lock.
- 11: error clear, bit 0.

Top module: `flash_wp_filter`

## Requirements
- R1: After reset, `cmd_ready`=1, `fwd_valid`=0, `blocked`=0 and `err_flag`=0. All windows are disabled, the type table is all 0 (read type), write-enable is 0 and all locks are clear.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. In the next cycle, exactly one of two outputs is high: `fwd_valid` (carrying the same opcode index and address) or `blocked`. `cmd_ready` stays low while either is high.
- R3: A command whose opcode index has a 0 in the type table is always forwarded, whatever its address and whatever the write-enable bit holds.
- R4: When the write-enable bit (control bit 0) is 0, every write-type command is blocked, independent of address.
- R5: When write-enable is 1, a write-type command is blocked if and only if some enabled window i satisfies base_i <= address <= limit_i, with both bounds inclusive.
- R6: While `fwd_valid` is high and `fwd_ready` is low, `fwd_valid`, `fwd_opidx` and `fwd_addr` hold their values.
- R7: `blocked` lasts one cycle. `err_flag` goes high in that same cycle and stays high until a write of 1 to bit 0 of address 11. A write of 0 has no effect. If a block and a clear land on the same edge, the flag stays set.
- R8: Lock bits (control bits 1..3) are set by writing 1. Writing 0 never clears them; only reset does.
- R9: While the window lock (control bit 2) is set, writes to addresses 0..8 are dropped.
- R10: While the type-table lock (control bit 3) is set, writes to address 9 are dropped.
- R11: While the write-enable lock (control bit 1) is set, writes to control bit 0 are dropped. A control write that sets this lock also applies its bit 0, because the lock was still clear at that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cmd_valid | input | 1 | Incoming command valid |
| cmd_ready | output | 1 | Filter can accept a command |
| cmd_opidx | input | 3 | Incoming opcode index |
| cmd_addr | input | 24 | Incoming flash address |
| fwd_valid | output | 1 | Forwarded command valid |
| fwd_ready | input | 1 | Controller accepts forwarded command |
| fwd_opidx | output | 3 | Forwarded opcode index |
| fwd_addr | output | 24 | Forwarded flash address |
| blocked | output | 1 | One-cycle pulse for a dropped command |
| err_flag | output | 1 | Sticky dropped-command flag |

## Verification
The hardest case to reach from the ports is the same-edge collision between a blocking decision and a software clear of the error flag. Reaching it needs a configuration write and a command acceptance timed onto one edge, and the bench drives both from the same falling edge to hit it. The lock behaviour is also hard to observe, because the registers cannot be read back. The bench therefore shows it through forwarding results. It attempts to undo a window, the type table or write-enable after locking, then sends commands whose outcome would flip if the write had landed. A second reset confirms that the locks release.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_BLOCK = 2'd2
    } fsm_state_t;

    localparam int CTRL_WREN_BIT  = 0;
    localparam int CTRL_GLOCK_BIT = 1;
    localparam int CTRL_RLOCK_BIT = 2;
    localparam int CTRL_TLOCK_BIT = 3;
endpackage

// File: rtl/wp_cfg_regs.sv
module wp_cfg_regs #(
    parameter int ADDR_W     = 24,
    parameter int NUM_RANGES = 4,
    parameter int OPIDX_W    = 3,
    parameter int CFG_AW     = 4,
    parameter int CFG_DW     = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_we,
    input  logic [CFG_AW-1:0]                   cfg_addr,
    input  logic [CFG_DW-1:0]                   cfg_wdata,
    input  logic                                set_err,
    output logic [NUM_RANGES-1:0][ADDR_W-1:0]   base,
    output logic [NUM_RANGES-1:0][ADDR_W-1:0]   limit,
    output logic [NUM_RANGES-1:0]               range_en,
    output logic [(1<<OPIDX_W)-1:0]             op_type,
    output logic                                wr_en,
    output logic                                gbl_lock,
    output logic                                range_lock,
    output logic                                type_lock,
    output logic                                err_flag
);
    import flash_wp_pkg::*;

    localparam int NUM_OPS   = 1 << OPIDX_W;
    localparam int A_EN      = 2 * NUM_RANGES;
    localparam int A_TYPE    = A_EN + 1;
    localparam int A_CTRL    = A_EN + 2;
    localparam int A_ERRCLR  = A_EN + 3;

    logic clr_hit;
    assign clr_hit = cfg_we && (cfg_addr == CFG_AW'(A_ERRCLR)) && cfg_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base       <= '0;
            limit      <= '0;
            range_en   <= '0;
            op_type    <= '0;
            wr_en      <= 1'b0;
            gbl_lock   <= 1'b0;
            range_lock <= 1'b0;
            type_lock  <= 1'b0;
        end else if (cfg_we) begin
            for (int i = 0; i < NUM_RANGES; i++) begin
                if (!range_lock && cfg_addr == CFG_AW'(i))
                    base[i] <= cfg_wdata[ADDR_W-1:0];
                if (!range_lock && cfg_addr == CFG_AW'(NUM_RANGES + i))
                    limit[i] <= cfg_wdata[ADDR_W-1:0];
            end
            if (!range_lock && cfg_addr == CFG_AW'(A_EN))
                range_en <= cfg_wdata[NUM_RANGES-1:0];
            if (!type_lock && cfg_addr == CFG_AW'(A_TYPE))
                op_type <= cfg_wdata[NUM_OPS-1:0];
            if (cfg_addr == CFG_AW'(A_CTRL)) begin
                if (!gbl_lock)
                    wr_en <= cfg_wdata[CTRL_WREN_BIT];
                gbl_lock   <= gbl_lock   | cfg_wdata[CTRL_GLOCK_BIT];
                range_lock <= range_lock | cfg_wdata[CTRL_RLOCK_BIT];
                type_lock  <= type_lock  | cfg_wdata[CTRL_TLOCK_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            err_flag <= 1'b0;
        else if (set_err)
            err_flag <= 1'b1;
        else if (clr_hit)
            err_flag <= 1'b0;
    end
endmodule

// File: rtl/wp_range_match.sv
module wp_range_match #(
    parameter int ADDR_W     = 24,
    parameter int NUM_RANGES = 4
) (
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [NUM_RANGES-1:0][ADDR_W-1:0]   base,
    input  logic [NUM_RANGES-1:0][ADDR_W-1:0]   limit,
    input  logic [NUM_RANGES-1:0]               range_en,
    output logic                                any_hit
);
    logic [NUM_RANGES-1:0] hit;

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
        assign hit[g] = range_en[g] && (addr >= base[g]) && (addr <= limit[g]);
    end

    assign any_hit = |hit;
endmodule

// File: rtl/wp_cmd_fsm.sv
module wp_cmd_fsm #(
    parameter int ADDR_W  = 24,
    parameter int OPIDX_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [OPIDX_W-1:0] cmd_opidx,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic               deny,
    input  logic               fwd_ready,
    output logic               cmd_ready,
    output logic               fwd_valid,
    output logic [OPIDX_W-1:0] fwd_opidx,
    output logic [ADDR_W-1:0]  fwd_addr,
    output logic               blocked,
    output logic               set_err
);
    import flash_wp_pkg::*;

    fsm_state_t state, state_nx;
    logic       accept;

    assign accept  = cmd_valid && (state == ST_IDLE);
    assign set_err = accept && deny;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            fwd_opidx <= '0;
            fwd_addr  <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                fwd_opidx <= cmd_opidx;
                fwd_addr  <= cmd_addr;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = deny ? ST_BLOCK : ST_PASS;
            ST_PASS:  if (fwd_ready) state_nx = ST_IDLE;
            ST_BLOCK: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_ready = 1'b0;
        fwd_valid = 1'b0;
        blocked   = 1'b0;
        unique case (state)
            ST_IDLE:  cmd_ready = 1'b1;
            ST_PASS:  fwd_valid = 1'b1;
            ST_BLOCK: blocked   = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/flash_wp_filter.sv
module flash_wp_filter #(
    parameter int ADDR_W     = 24,
    parameter int NUM_RANGES = 4,
    parameter int OPIDX_W    = 3,
    parameter int CFG_AW     = 4,
    parameter int CFG_DW     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [CFG_DW-1:0]  cfg_wdata,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [OPIDX_W-1:0] cmd_opidx,
    input  logic [ADDR_W-1:0]  cmd_addr,
    output logic               fwd_valid,
    input  logic               fwd_ready,
    output logic [OPIDX_W-1:0] fwd_opidx,
    output logic [ADDR_W-1:0]  fwd_addr,
    output logic               blocked,
    output logic               err_flag
);
    localparam int NUM_OPS = 1 << OPIDX_W;

    logic [NUM_RANGES-1:0][ADDR_W-1:0] base;
    logic [NUM_RANGES-1:0][ADDR_W-1:0] limit;
    logic [NUM_RANGES-1:0]             range_en;
    logic [NUM_OPS-1:0]                op_type;
    logic wr_en, gbl_lock, range_lock, type_lock;
    logic range_hit, is_write, deny, set_err;

    wp_cfg_regs #(
        .ADDR_W(ADDR_W), .NUM_RANGES(NUM_RANGES), .OPIDX_W(OPIDX_W),
        .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .set_err(set_err), .base(base), .limit(limit),
        .range_en(range_en), .op_type(op_type), .wr_en(wr_en),
        .gbl_lock(gbl_lock), .range_lock(range_lock), .type_lock(type_lock),
        .err_flag(err_flag)
    );

    wp_range_match #(.ADDR_W(ADDR_W), .NUM_RANGES(NUM_RANGES)) u_match (
        .addr(cmd_addr), .base(base), .limit(limit), .range_en(range_en),
        .any_hit(range_hit)
    );

    assign is_write = op_type[cmd_opidx];
    assign deny     = is_write && (!wr_en || range_hit);

    wp_cmd_fsm #(.ADDR_W(ADDR_W), .OPIDX_W(OPIDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opidx(cmd_opidx),
        .cmd_addr(cmd_addr), .deny(deny), .fwd_ready(fwd_ready),
        .cmd_ready(cmd_ready), .fwd_valid(fwd_valid), .fwd_opidx(fwd_opidx),
        .fwd_addr(fwd_addr), .blocked(blocked), .set_err(set_err)
    );
endmodule

// File: rtl/wp_filter_checker.sv
module wp_filter_checker #(
    parameter int ADDR_W     = 24,
    parameter int NUM_RANGES = 4,
    parameter int OPIDX_W    = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cmd_valid,
    input logic                      cmd_ready,
    input logic [OPIDX_W-1:0]        cmd_opidx,
    input logic                      fwd_valid,
    input logic                      fwd_ready,
    input logic [OPIDX_W-1:0]        fwd_opidx,
    input logic [ADDR_W-1:0]         fwd_addr,
    input logic                      blocked,
    input logic                      err_flag,
    input logic                      wr_en,
    input logic                      gbl_lock,
    input logic                      range_lock,
    input logic                      type_lock,
    input logic [NUM_RANGES-1:0]     range_en,
    input logic [(1<<OPIDX_W)-1:0]   op_type
);
    p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (fwd_valid != blocked));
    p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid || blocked) |-> !cmd_ready);
    p_read_passes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !op_type[cmd_opidx]) |=> fwd_valid);
    p_global_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && op_type[cmd_opidx] && !wr_en) |=> blocked);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr) && $stable(fwd_opidx)));
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> !blocked);
    p_err_with_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> err_flag);
    p_glock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gbl_lock |=> gbl_lock);
    p_rlock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        range_lock |=> range_lock);
    p_tlock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        type_lock |=> type_lock);
    p_ranges_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        range_lock |=> $stable(range_en));
    p_types_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        type_lock |=> $stable(op_type));
    p_wren_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        gbl_lock |=> $stable(wr_en));
endmodule

bind flash_wp_filter wp_filter_checker #(
    .ADDR_W(ADDR_W), .NUM_RANGES(NUM_RANGES), .OPIDX_W(OPIDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_opidx(cmd_opidx), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
    .fwd_opidx(fwd_opidx), .fwd_addr(fwd_addr), .blocked(blocked),
    .err_flag(err_flag), .wr_en(wr_en), .gbl_lock(gbl_lock),
    .range_lock(range_lock), .type_lock(type_lock), .range_en(range_en),
    .op_type(op_type)
);

// File: tb/sim_flash_wp_filter.sv
`timescale 1ns/1ps
module sim_flash_wp_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_opidx = '0;
    logic [23:0] cmd_addr = '0;
    logic        fwd_valid;
    logic        fwd_ready = 1'b0;
    logic [2:0]  fwd_opidx;
    logic [23:0] fwd_addr;
    logic        blocked;
    logic        err_flag;

    int total = 0;
    int bad = 0;

    logic [23:0] m_base [4];
    logic [23:0] m_lim  [4];
    logic [3:0]  m_en;
    logic [7:0]  m_type;
    logic        m_wren;

    always #2.5 clk = ~clk;

    flash_wp_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_opidx(cmd_opidx), .cmd_addr(cmd_addr), .fwd_valid(fwd_valid),
        .fwd_ready(fwd_ready), .fwd_opidx(fwd_opidx), .fwd_addr(fwd_addr),
        .blocked(blocked), .err_flag(err_flag)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit model_block(input logic [2:0] op, input logic [23:0] a);
        bit hit = 0;
        for (int i = 0; i < 4; i++)
            if (m_en[i] && a >= m_base[i] && a <= m_lim[i]) hit = 1;
        return m_type[op] && (!m_wren || hit);
    endfunction

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [23:0] a, input int stall,
                           input bit exp_blk, input string req);
        @(negedge clk);
        check(cmd_ready == 1'b1, "R2 ready in idle", {31'd0, cmd_ready}, 32'd1);
        cmd_valid = 1'b1; cmd_opidx = op; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0;
        check({fwd_valid, blocked} == (exp_blk ? 2'b01 : 2'b10), req,
              {30'd0, fwd_valid, blocked}, exp_blk ? 32'd1 : 32'd2);
        check(cmd_ready == 1'b0, "R2 busy not ready", {31'd0, cmd_ready}, 32'd0);
        if (exp_blk) begin
            check(err_flag == 1'b1, "R7 err with pulse", {31'd0, err_flag}, 32'd1);
            @(negedge clk);
            check(blocked == 1'b0 && cmd_ready == 1'b1, "R7 single pulse",
                  {30'd0, blocked, cmd_ready}, 32'd1);
        end else begin
            check(fwd_addr == a && fwd_opidx == op, "R2 forwarded fields",
                  {5'd0, fwd_opidx, fwd_addr}, {5'd0, op, a});
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                check(fwd_valid && fwd_addr == a && fwd_opidx == op, "R6 hold",
                      {4'd0, fwd_valid, fwd_opidx, fwd_addr}, {4'd1, op, a});
            end
            fwd_ready = 1'b1;
            @(negedge clk);
            fwd_ready = 1'b0;
            check(fwd_valid == 1'b0 && cmd_ready == 1'b1, "R6 release",
                  {30'd0, fwd_valid, cmd_ready}, 32'd1);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin m_base[i] = '0; m_lim[i] = '0; end
        m_en = '0; m_type = '0; m_wren = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [23:0] pts [16];
        do_reset();
        @(negedge clk);
        check(cmd_ready && !fwd_valid && !blocked && !err_flag, "R1 reset state",
              {28'd0, cmd_ready, fwd_valid, blocked, err_flag}, 32'h8);
        // R3: reset table is all read type; write-enable 0 still forwards
        for (int op = 0; op < 8; op++) run_cmd(3'(op), 24'h000150, op % 3, 1'b0, "R3 reset read type");

        m_base[0] = 24'h000100; m_lim[0] = 24'h0001FF;
        m_base[1] = 24'h800000; m_lim[1] = 24'h800000;
        m_base[2] = 24'h400000; m_lim[2] = 24'h4FFFFF;
        m_base[3] = 24'hFFFF00; m_lim[3] = 24'hFFFFFF;
        m_en = 4'b1011; m_type = 8'b1010_0110;
        for (int i = 0; i < 4; i++) begin
            cfg_write(4'(i), {8'd0, m_base[i]});
            cfg_write(4'(4 + i), {8'd0, m_lim[i]});
        end
        cfg_write(4'd8, {28'd0, m_en});
        cfg_write(4'd9, {24'd0, m_type});

        for (int i = 0; i < 4; i++) begin
            pts[4*i]   = m_base[i] - 24'd1;
            pts[4*i+1] = m_base[i];
            pts[4*i+2] = m_lim[i];
            pts[4*i+3] = m_lim[i] + 24'd1;
        end
        // R4 sweep with write-enable 0, R5 sweep with write-enable 1
        for (int w = 0; w < 2; w++) begin
            m_wren = w[0];
            cfg_write(4'd10, {31'd0, m_wren});
            for (int op = 0; op < 8; op++)
                for (int p = 0; p < 16; p++)
                    run_cmd(3'(op), pts[p], (op + p) % 3, model_block(3'(op), pts[p]),
                            w == 0 ? "R4 global sweep" : "R5 window sweep");
        end

        // R7 clear, ignored zero write, set-wins collision
        cfg_write(4'd11, 32'd0);
        @(negedge clk);
        check(err_flag == 1'b1, "R7 zero write keeps flag", {31'd0, err_flag}, 32'd1);
        cfg_write(4'd11, 32'd1);
        @(negedge clk);
        check(err_flag == 1'b0, "R7 clear", {31'd0, err_flag}, 32'd0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'd11; cfg_wdata = 32'd1;
        cmd_valid = 1'b1; cmd_opidx = 3'd1; cmd_addr = 24'h000100;
        @(negedge clk);
        cfg_we = 1'b0; cmd_valid = 1'b0;
        check(blocked && err_flag, "R7 set wins over clear", {30'd0, blocked, err_flag}, 32'd3);
        @(negedge clk);

        // R9 window lock, R8 zero write does not unlock
        cfg_write(4'd10, 32'h5);
        cfg_write(4'd10, 32'h1);
        cfg_write(4'd8, 32'd0);
        cfg_write(4'd0, 32'h000300);
        run_cmd(3'd1, 24'h000150, 1, 1'b1, "R9 window writes dropped");
        run_cmd(3'd1, 24'h000300, 0, 1'b0, "R9 base write dropped");
        run_cmd(3'd2, 24'h800000, 0, 1'b1, "R8 window lock stays");

        // R10 type lock
        cfg_write(4'd10, 32'h9);
        cfg_write(4'd9, 32'hFF);
        run_cmd(3'd0, 24'h000150, 2, 1'b0, "R10 type write dropped");
        run_cmd(3'd3, 24'hFFFF80, 0, 1'b0, "R10 read type kept");

        // R11 write-enable lock with enable 1
        cfg_write(4'd10, 32'h3);
        cfg_write(4'd10, 32'h0);
        run_cmd(3'd1, 24'h000300, 0, 1'b0, "R11 enable cannot clear");

        // R1/R8 reset releases locks; R11 lock with enable 0
        do_reset();
        @(negedge clk);
        check(cmd_ready && !fwd_valid && !blocked && !err_flag, "R1 reset after locks",
              {28'd0, cmd_ready, fwd_valid, blocked, err_flag}, 32'h8);
        cfg_write(4'd9, 32'h02);
        run_cmd(3'd1, 24'h000010, 0, 1'b1, "R8 reset releases type lock");
        cfg_write(4'd10, 32'h2);
        cfg_write(4'd10, 32'h1);
        run_cmd(3'd1, 24'h000010, 0, 1'b1, "R11 enable cannot set");
        run_cmd(3'd0, 24'h000010, 1, 1'b0, "R3 read type under lock");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule